// File: doc/BRIEF.md
# Performance-Monitor User-Access Trap Controller

This block keeps the four-bit user-enable control word of a performance-monitor unit. For every system-register access presented to it, the block decides whether the access goes ahead, is undefined, or traps to a higher privilege level. An access gives the current privilege level (0 to 3), a read/write flag, write data and a class code that names the target register. The configuration bits that higher levels own also feed the decision: the level-2 enable, the 64-bit mode flags for levels 2 and 3, the level-2 coprocessor trap bit, the level-2 and level-3 monitor trap bits, and the two-bit host-mode pair.

At level 0, the global enable opens most monitor registers. While the global enable is clear, three override bits each open one resource. The control word can only be read at level 0. Every access to the control word first passes a fixed-priority chain of higher-level trap checks. The verdict arrives one clock after the access strobe as a one-hot result with an 8-bit syndrome. A write to the control word takes effect only when the verdict is allow. The counters themselves are outside this block, so an allowed access to any other class returns zero read data.

Top module: `pmu_uaccess_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, `rsp_valid` is 0 and the control word is 0. A level-3 read of it returns zero data.
- R2: Control-word bit 0 is the global enable (EN), bit 1 the software-increment override (SW), bit 2 the cycle-counter override (CR) and bit 3 the event-counter override (ER). An allowed read returns the word in bits [3:0] and zeros in bits [31:4]. Write data bits [31:4] are dropped.
- R3: Each access with `acc_valid` high produces exactly one response on the following cycle. `rsp_kind` is one-hot: bit 0 allow, bit 1 undefined, bit 2 hypervisor trap, bit 3 trap to level 2, bit 4 trap to level 3. It is all-zero when no response is due.
- R4: A level-0 write to the control word (class 0) is undefined. A level-0 read of it is allowed unless the trap chain fires.
- R5: At level 0 with EN=1, every class is allowed except class 5 (interrupt enable set/clear), which is undefined. Class codes: 0 control word, 1 event counter, 2 event select, 3 cycle counter, 4 software increment, 5 interrupt enable set/clear, 6 and 7 other monitor registers.
- R6: At level 0 with EN=0, an access is undefined unless an override applies. ER allows event-counter reads and event-select reads and writes. CR allows cycle-counter reads and writes. SW allows software-increment writes.
- R7: For control-word accesses at levels 0 and 1, the chain is checked in this order: coprocessor trap with level 2 in 64-bit mode gives trap-to-2; coprocessor trap with level 2 in 32-bit mode gives hyp trap; monitor trap with level 2 in 64-bit mode gives trap-to-2; monitor trap with level 2 in 32-bit mode gives hyp trap; level-3 monitor trap with level 3 present and in 64-bit mode gives trap-to-3; anything else is allowed.
- R8: At level 0 only, the first chain check is skipped when the host-mode pair equals 2'b11.
- R9: With the level-2 enable at 0, every level-2 check is skipped.
- R10: At level 2, only the level-3 monitor-trap check applies. At level 3, every access is allowed.
- R11: `rsp_syn` is 8'h03 for the hyp, trap-to-2 and trap-to-3 results, and 0 otherwise.
- R12: Read data is zero unless the result is allow. The control word changes only on an allowed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_lvl | input | 2 | Privilege level of the access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_class | input | 3 | Target class code |
| l2_on | input | 1 | Level 2 present and enabled |
| l2_wide | input | 1 | Level 2 in 64-bit mode |
| l3_on | input | 1 | Level 3 present |
| l3_wide | input | 1 | Level 3 in 64-bit mode |
| l2_cp_trap | input | 1 | Level-2 coprocessor trap bit |
| l2_mon_trap | input | 1 | Level-2 monitor trap bit |
| l3_mon_trap | input | 1 | Level-3 monitor trap bit |
| host_pair | input | 2 | Host-mode pair |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 5 | One-hot result |
| rsp_syn | output | 8 | Syndrome code |
| rsp_rdata | output | 32 | Read data |

## Verification
Every result, including read data and syndrome, is registered. It is due on the cycle after the clock edge that samples the access strobe. A write to the control word also takes effect at that same edge, so the next access already sees the new value. The driver applies an access at a falling edge and pushes the expected item into a queue. The monitor samples at each falling edge and pops one item for each `rsp_valid`, so a response that comes late, early, twice or not at all appears as a mismatch or as a leftover item in the queue.

// File: rtl/pmu_uaccess_pkg.sv
package pmu_uaccess_pkg;
  localparam int UEN_W  = 4;
  localparam int UEN_EN = 0;
  localparam int UEN_SW = 1;
  localparam int UEN_CR = 2;
  localparam int UEN_ER = 3;

  typedef enum logic [2:0] {
    TGT_CTRL  = 3'd0,
    TGT_EVCNT = 3'd1,
    TGT_EVSEL = 3'd2,
    TGT_CYC   = 3'd3,
    TGT_SWINC = 3'd4,
    TGT_IRQEN = 3'd5,
    TGT_OTH6  = 3'd6,
    TGT_OTH7  = 3'd7
  } tgt_e;

  typedef enum logic [4:0] {
    RES_NONE  = 5'b00000,
    RES_ALLOW = 5'b00001,
    RES_UNDEF = 5'b00010,
    RES_HYP   = 5'b00100,
    RES_TRAP2 = 5'b01000,
    RES_TRAP3 = 5'b10000
  } res_e;
endpackage

// File: rtl/pmu_rst_sync.sv
module pmu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmu_uen_reg.sv
module pmu_uen_reg #(
  parameter int W = pmu_uaccess_pkg::UEN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] uen_q
);
  logic [W-1:0] uen_d;

  always_comb begin
    uen_d = uen_q;
    if (wr_en) uen_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uen_q <= '0;
    else        uen_q <= uen_d;
  end
endmodule

// File: rtl/pmu_trap_chain.sv
module pmu_trap_chain
  import pmu_uaccess_pkg::*;
(
  input  logic [1:0] lvl,
  input  logic       l2_on,
  input  logic       l2_wide,
  input  logic       l3_on,
  input  logic       l3_wide,
  input  logic       l2_cp_trap,
  input  logic       l2_mon_trap,
  input  logic       l3_mon_trap,
  input  logic [1:0] host_pair,
  output res_e       chain_res
);
  logic l2_chk;
  logic host_skip;

  always_comb begin
    // level-2 checks only run below level 2 and with level 2 enabled
    l2_chk    = l2_on && (lvl < 2'd2);
    host_skip = (lvl == 2'd0) && (host_pair == 2'b11);
    chain_res = RES_ALLOW;
    if (lvl == 2'd3)                                       chain_res = RES_ALLOW;
    else if (l2_chk && l2_wide && l2_cp_trap && !host_skip) chain_res = RES_TRAP2;
    else if (l2_chk && !l2_wide && l2_cp_trap)             chain_res = RES_HYP;
    else if (l2_chk && l2_wide && l2_mon_trap)             chain_res = RES_TRAP2;
    else if (l2_chk && !l2_wide && l2_mon_trap)            chain_res = RES_HYP;
    else if (l3_on && l3_wide && l3_mon_trap)              chain_res = RES_TRAP3;
  end
endmodule

// File: rtl/pmu_user_gate.sv
module pmu_user_gate
  import pmu_uaccess_pkg::*;
(
  input  logic [UEN_W-1:0] uen,
  input  tgt_e             tgt,
  input  logic             wr,
  output logic             user_ok
);
  always_comb begin
    user_ok = 1'b0;
    if (tgt == TGT_IRQEN) begin
      user_ok = 1'b0;
    end else if (uen[UEN_EN]) begin
      user_ok = 1'b1;
    end else begin
      case (tgt)
        TGT_EVCNT: user_ok = uen[UEN_ER] && !wr;
        TGT_EVSEL: user_ok = uen[UEN_ER];
        TGT_CYC:   user_ok = uen[UEN_CR];
        TGT_SWINC: user_ok = uen[UEN_SW] && wr;
        default:   user_ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pmu_uaccess_ctl.sv
module pmu_uaccess_ctl
  import pmu_uaccess_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          SYN_W    = 8,
  parameter logic [7:0]  TRAP_SYN = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_lvl,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [2:0]        acc_class,
  input  logic              l2_on,
  input  logic              l2_wide,
  input  logic              l3_on,
  input  logic              l3_wide,
  input  logic              l2_cp_trap,
  input  logic              l2_mon_trap,
  input  logic              l3_mon_trap,
  input  logic [1:0]        host_pair,
  output logic              rsp_valid,
  output logic [4:0]        rsp_kind,
  output logic [SYN_W-1:0]  rsp_syn,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int PAD_W = DATA_W - UEN_W;

  logic              rst_sync_n;
  tgt_e              tgt;
  res_e              chain_res;
  res_e              res_d;
  logic              user_ok;
  logic [UEN_W-1:0]  uen_q;
  logic              ctrl_wr;
  logic [DATA_W-1:0] rdata_d;
  logic [SYN_W-1:0]  syn_d;
  logic              unused_hi;

  logic              valid_q;
  logic [4:0]        kind_q;
  logic [SYN_W-1:0]  syn_q;
  logic [DATA_W-1:0] rdata_q;

  assign tgt       = tgt_e'(acc_class);
  assign unused_hi = ^acc_wdata[DATA_W-1:UEN_W];

  pmu_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmu_trap_chain chain_i (
    .lvl         (acc_lvl),
    .l2_on       (l2_on),
    .l2_wide     (l2_wide),
    .l3_on       (l3_on),
    .l3_wide     (l3_wide),
    .l2_cp_trap  (l2_cp_trap),
    .l2_mon_trap (l2_mon_trap),
    .l3_mon_trap (l3_mon_trap),
    .host_pair   (host_pair),
    .chain_res   (chain_res)
  );

  pmu_user_gate gate_i (
    .uen     (uen_q),
    .tgt     (tgt),
    .wr      (acc_wr),
    .user_ok (user_ok)
  );

  pmu_uen_reg #(.W(UEN_W)) uen_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (ctrl_wr),
    .wdata (acc_wdata[UEN_W-1:0]),
    .uen_q (uen_q)
  );

  // verdict for the access presented this cycle
  always_comb begin
    if (tgt == TGT_CTRL) begin
      if (acc_lvl == 2'd0 && acc_wr) res_d = RES_UNDEF;
      else                           res_d = chain_res;
    end else if (acc_lvl == 2'd0) begin
      res_d = user_ok ? RES_ALLOW : RES_UNDEF;
    end else begin
      res_d = RES_ALLOW;
    end
  end

  always_comb begin
    ctrl_wr = acc_valid && (tgt == TGT_CTRL) && acc_wr && (res_d == RES_ALLOW);
    rdata_d = '0;
    if (acc_valid && (tgt == TGT_CTRL) && !acc_wr && (res_d == RES_ALLOW))
      rdata_d = {{PAD_W{1'b0}}, uen_q};
    syn_d = '0;
    if (acc_valid && (res_d == RES_HYP || res_d == RES_TRAP2 || res_d == RES_TRAP3))
      syn_d = TRAP_SYN;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      kind_q  <= RES_NONE;
      syn_q   <= '0;
      rdata_q <= '0;
    end else begin
      valid_q <= acc_valid;
      kind_q  <= acc_valid ? res_d : RES_NONE;
      syn_q   <= syn_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_kind  = kind_q;
  assign rsp_syn   = syn_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/pmu_uaccess_chk.sv
module pmu_uaccess_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [1:0]  acc_lvl,
  input logic        acc_wr,
  input logic [2:0]  acc_class,
  input logic        rsp_valid,
  input logic [4:0]  rsp_kind,
  input logic [7:0]  rsp_syn,
  input logic [31:0] rsp_rdata
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid); // R3
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid); // R3
  AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_kind) == 1); // R3
  AST_KIND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_kind == 5'b0); // R3
  AST_SYN_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_kind[2] || rsp_kind[3] || rsp_kind[4])) |-> rsp_syn == 8'h03); // R11
  AST_SYN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_kind[2] || rsp_kind[3] || rsp_kind[4]) |-> rsp_syn == 8'h00); // R11
  AST_RDATA_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_kind[0] |-> rsp_rdata == 32'h0); // R12
  AST_RES_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[31:4] == 28'h0); // R2
  AST_L0_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_lvl == 2'd0 && acc_wr && acc_class == 3'd0) |=> rsp_kind == 5'b00010); // R4
  AST_L0_IRQ_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_lvl == 2'd0 && acc_class == 3'd5) |=> rsp_kind == 5'b00010); // R5
  AST_L3_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_lvl == 2'd3) |=> rsp_kind == 5'b00001); // R10
endmodule

bind pmu_uaccess_ctl pmu_uaccess_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_valid (acc_valid),
  .acc_lvl   (acc_lvl),
  .acc_wr    (acc_wr),
  .acc_class (acc_class),
  .rsp_valid (rsp_valid),
  .rsp_kind  (rsp_kind),
  .rsp_syn   (rsp_syn),
  .rsp_rdata (rsp_rdata)
);

// File: tb/pmu_uaccess_ctl_tb_top.sv
module pmu_uaccess_ctl_tb_top;
  localparam logic [4:0] K_ALLOW = 5'b00001;
  localparam logic [4:0] K_UNDEF = 5'b00010;
  localparam logic [4:0] K_HYP   = 5'b00100;
  localparam logic [4:0] K_T2    = 5'b01000;
  localparam logic [4:0] K_T3    = 5'b10000;
  localparam logic [2:0] C_CTRL = 3'd0, C_EVC = 3'd1, C_EVS = 3'd2, C_CYC = 3'd3,
                         C_SWI = 3'd4, C_IRQ = 3'd5, C_OTH = 3'd6;

  typedef struct {
    logic [4:0]  kind;
    logic [7:0]  syn;
    logic [31:0] rdata;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_wr;
  logic [1:0]  acc_lvl;
  logic [31:0] acc_wdata;
  logic [2:0]  acc_class;
  logic        l2_on, l2_wide, l3_on, l3_wide, l2_cp_trap, l2_mon_trap, l3_mon_trap;
  logic [1:0]  host_pair;
  logic        rsp_valid;
  logic [4:0]  rsp_kind;
  logic [7:0]  rsp_syn;
  logic [31:0] rsp_rdata;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  pmu_uaccess_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_lvl(acc_lvl),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_class(acc_class),
    .l2_on(l2_on), .l2_wide(l2_wide), .l3_on(l3_on), .l3_wide(l3_wide),
    .l2_cp_trap(l2_cp_trap), .l2_mon_trap(l2_mon_trap), .l3_mon_trap(l3_mon_trap),
    .host_pair(host_pair), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_syn(rsp_syn), .rsp_rdata(rsp_rdata)
  );

  task automatic cfg(input logic on2, input logic w2, input logic cp, input logic mon2,
                     input logic [1:0] hp, input logic on3, input logic w3, input logic mon3);
    l2_on = on2; l2_wide = w2; l2_cp_trap = cp; l2_mon_trap = mon2;
    host_pair = hp; l3_on = on3; l3_wide = w3; l3_mon_trap = mon3;
  endtask

  // driver: one access per call, expected item queued for the monitor
  task automatic acc(input logic [1:0] lvl, input logic wr, input logic [2:0] cls,
                     input logic [31:0] wd, input logic [4:0] ek,
                     input logic [31:0] erd, input string tag);
    exp_t e;
    e.kind  = ek;
    e.syn   = (ek == K_HYP || ek == K_T2 || ek == K_T3) ? 8'h03 : 8'h00;
    e.rdata = erd;
    e.tag   = tag;
    exp_q.push_back(e);
    acc_lvl = lvl; acc_wr = wr; acc_class = cls; acc_wdata = wd; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // monitor: responses due one cycle after the strobe edge, sampled at negedge
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected response kind=%b expected none", rsp_kind);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_kind !== e.kind || rsp_syn !== e.syn || rsp_rdata !== e.rdata) begin
          n_fail++;
          $display("FAIL %s kind=%b syn=%h rdata=%h expected kind=%b syn=%h rdata=%h",
                   e.tag, rsp_kind, rsp_syn, rsp_rdata, e.kind, e.syn, e.rdata);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_wr = 1'b0; acc_lvl = 2'd0;
    acc_wdata = '0; acc_class = '0;
    cfg(0, 0, 0, 0, 2'b00, 0, 0, 0);
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_kind !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 reset rsp_valid=%b kind=%b expected 0/0", rsp_valid, rsp_kind);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    acc(3, 0, C_CTRL, 0, K_ALLOW, 32'h0, "R1 reset value");
    acc(0, 1, C_CTRL, 32'hF, K_UNDEF, 32'h0, "R4 level0 write");
    acc(3, 0, C_CTRL, 0, K_ALLOW, 32'h0, "R12 blocked write no effect");
    acc(1, 1, C_CTRL, 32'hFFFF_FFF5, K_ALLOW, 32'h0, "R2 level1 write");
    acc(1, 0, C_CTRL, 0, K_ALLOW, 32'h5, "R2 reserved bits zero");
    acc(0, 0, C_CTRL, 0, K_ALLOW, 32'h5, "R4 level0 read");
    // EN=1
    acc(0, 1, C_EVC, 0, K_ALLOW, 32'h0, "R5 event counter write");
    acc(0, 0, C_OTH, 0, K_ALLOW, 32'h0, "R5 other read");
    acc(0, 1, C_IRQ, 0, K_UNDEF, 32'h0, "R5 irq enable");
    acc(0, 0, C_IRQ, 0, K_UNDEF, 32'h0, "R5 irq enable read");
    acc(2, 1, C_CTRL, 32'h8, K_ALLOW, 32'h0, "R10 level2 write");
    // ER only
    acc(0, 0, C_EVC, 0, K_ALLOW, 32'h0, "R6 ER counter read");
    acc(0, 1, C_EVC, 0, K_UNDEF, 32'h0, "R6 ER counter write");
    acc(0, 1, C_EVS, 0, K_ALLOW, 32'h0, "R6 ER select write");
    acc(0, 0, C_CYC, 0, K_UNDEF, 32'h0, "R6 cycle w/o CR");
    acc(0, 1, C_SWI, 0, K_UNDEF, 32'h0, "R6 swinc w/o SW");
    acc(0, 0, C_OTH, 0, K_UNDEF, 32'h0, "R6 other w/o EN");
    acc(3, 1, C_CTRL, 32'h4, K_ALLOW, 32'h0, "R10 level3 write");
    acc(0, 1, C_CYC, 0, K_ALLOW, 32'h0, "R6 CR cycle write");
    acc(0, 0, C_EVS, 0, K_UNDEF, 32'h0, "R6 select w/o ER");
    acc(3, 1, C_CTRL, 32'h2, K_ALLOW, 32'h0, "R10 level3 write");
    acc(0, 1, C_SWI, 0, K_ALLOW, 32'h0, "R6 SW swinc write");
    acc(0, 0, C_SWI, 0, K_UNDEF, 32'h0, "R6 SW swinc read");
    // trap chain, control word = 2
    cfg(1, 1, 1, 0, 2'b00, 0, 0, 0);
    acc(0, 0, C_CTRL, 0, K_T2, 32'h0, "R7 cp trap wide");
    cfg(1, 1, 1, 0, 2'b11, 0, 0, 0);
    acc(0, 0, C_CTRL, 0, K_ALLOW, 32'h2, "R8 host pair skips level0");
    acc(1, 0, C_CTRL, 0, K_T2, 32'h0, "R8 host pair ignored level1");
    cfg(1, 1, 1, 1, 2'b11, 0, 0, 0);
    acc(0, 0, C_CTRL, 0, K_T2, 32'h0, "R8 falls to monitor trap");
    cfg(1, 0, 1, 0, 2'b00, 0, 0, 0);
    acc(0, 0, C_CTRL, 0, K_HYP, 32'h0, "R7 cp trap narrow R11");
    cfg(1, 1, 0, 1, 2'b00, 0, 0, 0);
    acc(1, 0, C_CTRL, 0, K_T2, 32'h0, "R7 mon trap wide");
    cfg(1, 0, 0, 1, 2'b00, 0, 0, 0);
    acc(1, 1, C_CTRL, 32'hF, K_HYP, 32'h0, "R7 mon trap narrow write");
    acc(3, 0, C_CTRL, 0, K_ALLOW, 32'h2, "R12 trapped write no effect");
    cfg(0, 0, 0, 0, 2'b00, 1, 1, 1);
    acc(0, 0, C_CTRL, 0, K_T3, 32'h0, "R7 level3 trap R11");
    cfg(0, 0, 0, 0, 2'b00, 1, 0, 1);
    acc(1, 0, C_CTRL, 0, K_ALLOW, 32'h2, "R7 level3 narrow allow");
    cfg(1, 1, 1, 1, 2'b00, 1, 1, 1);
    acc(1, 0, C_CTRL, 0, K_T2, 32'h0, "R7 priority first wins");
    cfg(0, 1, 1, 1, 2'b00, 1, 1, 1);
    acc(1, 0, C_CTRL, 0, K_T3, 32'h0, "R9 level2 disabled");
    cfg(1, 1, 1, 1, 2'b00, 0, 0, 0);
    acc(2, 0, C_CTRL, 0, K_ALLOW, 32'h2, "R10 level2 ignores l2 traps");
    cfg(1, 1, 1, 1, 2'b00, 1, 1, 1);
    acc(2, 1, C_CTRL, 32'h1, K_T3, 32'h0, "R10 level2 l3 trap");
    acc(3, 0, C_CTRL, 0, K_ALLOW, 32'h2, "R10 level3 always");

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3 missing responses=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule